// File: doc/BRIEF.md
# Square-Wave Output and Oscillator-Status Control

This block holds the timekeeper's 8-bit output-control register. It chooses what the open-drain square-wave pin shows. When the wave is enabled, the pin follows one of four divider taps: 1 Hz, 4.096 kHz, 8.192 kHz or 32.768 kHz. When the wave is disabled, the pin holds a static level that software programs. The block also keeps a sticky flag that records when the oscillator stopped. Software can only clear this flag, and the flag wins over a clear that arrives in the same cycle.

The divider taps come from the timekeeping divider outside this block. When software writes the seconds register, that divider is reset, so the 1 Hz wave realigns with the write. The oscillator-stopped indication is asynchronous and passes through a synchronizer. The clock-halt bit is already synchronous. The block contains a control half and a datapath half. The control half turns raw inputs into strobes. The datapath half holds the register and the registered pin level.

Top module: `sqw_status_top`

## Requirements
- R1: After reset the register reads 0xB3, so the wave is enabled at the fastest rate, the static level is 1 and the stop flag is set. One cycle after reset is released, the pin follows the 32.768 kHz tap.
- R2: Readback places the static level at bit 7, the stop flag at bit 5, the wave enable at bit 4 and the rate select at bits 1:0. Bits 6, 3 and 2 always read 0, whatever was written to them.
- R3: With the enable set, rate select 0, 1, 2 and 3 choose tap 0 (1 Hz), tap 1 (4.096 kHz), tap 2 (8.192 kHz) and tap 3 (32.768 kHz). The pin level equals the chosen tap one clock later, so the 1 Hz wave keeps the phase of the divider.
- R4: With the enable clear, the pin level equals the static bit one clock later, and tap activity has no effect on it.
- R5: A register write with bit 5 at 0 clears the stop flag. A write with bit 5 at 1 leaves the flag unchanged.
- R6: A 0-to-1 change of the stopped indication sets the flag two clocks after it enters the synchronizer. The flag is set at the third rising edge after the change, and it is still clear at the second. Holding the indication high does not set the flag again after software clears it.
- R7: A 0-to-1 change of the clock-halt bit sets the flag at the next rising edge.
- R8: If a set event and a clearing write happen in the same cycle, the flag ends up set.
- R9: The open-drain enable output is 1, pulling the pin low, exactly when the registered pin level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divTaps | input | 4 | Divider taps: [0] 1 Hz, [1] 4.096 kHz, [2] 8.192 kHz, [3] 32.768 kHz |
| oscStopped | input | 1 | Asynchronous oscillator-stopped indication |
| haltBit | input | 1 | Clock-halt bit from the seconds register |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register readback |
| sqwPullLow | output | 1 | Open-drain enable, 1 pulls the pin low |

## Verification
The bench goes after the edges of the stop flag. A design that set the flag on the level of the stopped indication would set it again right after software cleared it. A design that let a clearing write win would lose a stop that came in the same cycle. A design that honoured a written 1 would let software fake a stop. The bench also changes taps while the wave is disabled, because a wrong mux would leak the wave onto the static level. It writes all ones and then only the reserved bits, to catch a wrong field position and reserved bits that read back.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int REG_W    = 8;
  localparam int OUT_BIT  = 7;
  localparam int OSF_BIT  = 5;
  localparam int EN_BIT   = 4;
  localparam int RATE_LSB = 0;
  localparam int RATE_W   = 2;

  typedef struct packed {
    logic             cfgWrite;   // load level, enable and rate
    logic             osfSet;     // stop event seen this cycle
    logic             osfClear;   // software writes 0 to flag
    logic             newOut;
    logic             newEn;
    logic [RATE_W-1:0] newRate;
  } sqw_strobe_t;
endpackage

// File: rtl/sqw_ctrl.sv
module sqw_ctrl
  import sqw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscStopped,
  input  logic             haltBit,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output sqw_strobe_t      strobes
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic stopPrev;
  logic stopNow;
  logic unusedWdata;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= oscStopped;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
        end
      end
    end
  endgenerate

  assign stopNow = syncChain[SYNC_STAGES-1] | haltBit;

  always_ff @(posedge clk) begin
    if (!rstN) stopPrev <= 1'b0;
    else       stopPrev <= stopNow;
  end

  assign unusedWdata = ^{regWdata[6], regWdata[3], regWdata[2]};

  always_comb begin
    strobes.cfgWrite = regWe;
    strobes.osfSet   = stopNow & ~stopPrev;
    strobes.osfClear = regWe & ~regWdata[OSF_BIT];
    strobes.newOut   = regWdata[OUT_BIT];
    strobes.newEn    = regWdata[EN_BIT];
    strobes.newRate  = regWdata[RATE_LSB +: RATE_W];
  end

  AST_SET_IS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.osfSet |=> !strobes.osfSet); // R6
endmodule

// File: rtl/sqw_datapath.sv
module sqw_datapath
  import sqw_pkg::*;
#(
  parameter int               NUM_TAPS  = 4,
  parameter logic [REG_W-1:0] RESET_VAL = 8'hB3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TAPS-1:0] divTaps,
  input  sqw_strobe_t         strobes,
  output logic [REG_W-1:0]    regRdata,
  output logic                sqwPullLow
);
  localparam int SEL_W = $clog2(NUM_TAPS);

  logic             outQ, osfQ, enQ, pinLevelQ;
  logic [SEL_W-1:0] rateQ;
  logic             pinNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outQ  <= RESET_VAL[OUT_BIT];
      enQ   <= RESET_VAL[EN_BIT];
      rateQ <= RESET_VAL[RATE_LSB +: SEL_W];
    end else if (strobes.cfgWrite) begin
      outQ  <= strobes.newOut;
      enQ   <= strobes.newEn;
      rateQ <= strobes.newRate[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 osfQ <= RESET_VAL[OSF_BIT];
    else if (strobes.osfSet)   osfQ <= 1'b1;
    else if (strobes.osfClear) osfQ <= 1'b0;
  end

  assign pinNext = enQ ? divTaps[rateQ] : outQ;

  always_ff @(posedge clk) begin
    if (!rstN) pinLevelQ <= 1'b1;
    else       pinLevelQ <= pinNext;
  end

  assign sqwPullLow = ~pinLevelQ;

  always_comb begin
    regRdata                       = '0;
    regRdata[OUT_BIT]              = outQ;
    regRdata[OSF_BIT]              = osfQ;
    regRdata[EN_BIT]               = enQ;
    regRdata[RATE_LSB +: SEL_W]    = rateQ;
  end

  AST_OSF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (osfQ && !strobes.osfClear) |=> osfQ); // R5
  AST_OSF_ONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!osfQ && strobes.cfgWrite && !strobes.osfClear && !strobes.osfSet) |=> !osfQ); // R5
  AST_OSF_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(osfQ) |-> $past(strobes.osfSet)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.osfSet |=> osfQ); // R8
  AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !strobes.cfgWrite) |=> (sqwPullLow == !$past(outQ))); // R4
endmodule

// File: rtl/sqw_status_top.sv
module sqw_status_top
  import sqw_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               NUM_TAPS    = 4,
  parameter logic [REG_W-1:0] RESET_VAL   = 8'hB3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_TAPS-1:0] divTaps,
  input  logic                oscStopped,
  input  logic                haltBit,
  input  logic                regWe,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  output logic                sqwPullLow
);
  sqw_strobe_t strobes;

  sqw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscStopped(oscStopped), .haltBit(haltBit),
    .regWe(regWe), .regWdata(regWdata), .strobes(strobes)
  );

  sqw_datapath #(.NUM_TAPS(NUM_TAPS), .RESET_VAL(RESET_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .divTaps(divTaps), .strobes(strobes),
    .regRdata(regRdata), .sqwPullLow(sqwPullLow)
  );
endmodule

// File: tb/sqw_status_top_bench.sv
module sqw_status_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] divTaps = 4'b0000;
  logic       oscStopped = 1'b0;
  logic       haltBit = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       sqwPullLow;
  int         nRun = 0;
  int         nFail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sqw_status_top u_sqw_status_top (
    .clk(clk), .rstN(rstN), .divTaps(divTaps), .oscStopped(oscStopped),
    .haltBit(haltBit), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .sqwPullLow(sqwPullLow)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic tReset();
    divTaps = 4'b1000;
    rstN = 1'b0; cyc(2); rstN = 1'b1;
    chk(regRdata, 8'hB3, "R1 reset readback");
    cyc(1);
    chk({7'b0, sqwPullLow}, 8'h00, "R1 pin follows 32k tap high");
    divTaps = 4'b0000; cyc(1);
    chk({7'b0, sqwPullLow}, 8'h01, "R1 pin follows 32k tap low");
  endtask

  task automatic tLayout();
    wr(8'hFF);
    chk(regRdata, 8'hB3, "R2 write all ones");
    wr(8'h4C);
    chk(regRdata, 8'h00, "R2 reserved bits read zero");
    wr(8'h82);
    chk(regRdata, 8'h82, "R2 level and rate fields");
  endtask

  task automatic tRates();
    for (int r = 0; r < 4; r++) begin
      wr(8'h10 | 8'(r));
      divTaps = 4'b0000; divTaps[r] = 1'b1; cyc(1);
      chk({7'b0, sqwPullLow}, 8'h00, $sformatf("R3 rate %0d tap high", r));
      divTaps = ~(4'b0001 << r); cyc(1);
      chk({7'b0, sqwPullLow}, 8'h01, $sformatf("R3 rate %0d tap low", r));
    end
    chk({7'b0, sqwPullLow ^ 1'b1}, 8'h00, "R9 pull low when level 0");
  endtask

  task automatic tStatic();
    wr(8'h80); cyc(1);
    for (int k = 0; k < 4; k++) begin
      divTaps = 4'(k * 5); cyc(1);
      chk({7'b0, sqwPullLow}, 8'h00, "R4 level 1 ignores taps");
    end
    wr(8'h03); cyc(1);
    divTaps = 4'hF; cyc(1);
    chk({7'b0, sqwPullLow}, 8'h01, "R4 level 0 ignores taps");
  endtask

  task automatic tOsfWrite();
    haltBit = 1'b0; oscStopped = 1'b0; cyc(4);
    wr(8'h00);
    chk(regRdata & 8'h20, 8'h00, "R5 write 0 clears flag");
    wr(8'h20);
    chk(regRdata & 8'h20, 8'h00, "R5 write 1 has no effect");
  endtask

  task automatic tOsfSync();
    wr(8'h00);
    oscStopped = 1'b1;
    cyc(2);
    chk(regRdata & 8'h20, 8'h00, "R6 flag clear at second edge");
    cyc(1);
    chk(regRdata & 8'h20, 8'h20, "R6 flag set at third edge");
    wr(8'h00); cyc(5);
    chk(regRdata & 8'h20, 8'h00, "R6 held level does not reset flag");
    oscStopped = 1'b0; cyc(4);
  endtask

  task automatic tHalt();
    wr(8'h00);
    haltBit = 1'b1; cyc(1);
    chk(regRdata & 8'h20, 8'h20, "R7 halt sets flag");
    haltBit = 1'b0; cyc(2);
  endtask

  task automatic tPriority();
    wr(8'h00);
    haltBit = 1'b1; regWe = 1'b1; regWdata = 8'h00;
    cyc(1);
    regWe = 1'b0;
    chk(regRdata & 8'h20, 8'h20, "R8 set beats clear");
    haltBit = 1'b0; cyc(2);
  endtask

  initial begin
    cyc(1);
    tReset();
    tLayout();
    tRates();
    tStatic();
    tOsfWrite();
    tOsfSync();
    tHalt();
    tPriority();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule